// File: doc/BRIEF.md
# Multi-Mode Reloadable Down-Counter Timer

This block is an 8-bit down-counter with a reload register, shared by four operating modes chosen by a 2-bit field. Its count pulses come from one of three places. The first is a slow tick at the system clock divided by 16. The second is a fast tick at the system clock divided by 2; a free-running divider inside the block produces both ticks. The third is an edge on the external timer pin. When the counter sits at zero and a count pulse arrives, it reloads from the reload register and raises an interrupt request. With a reload value n, the counter therefore divides its pulse stream by n+1.

The single polarity bit is read differently in each mode. In event mode it selects which pin edge is counted. In pulse-width mode it selects which pin level enables the source tick. In pulse-output mode it sets the level the pin drives first. A stop bit freezes the counter in every mode. While stopped, a write to the reload register also places the value into the counter, which is how software presets it. Software sees the live count and a sticky interrupt flag that it clears with a strobe. Bus decoding and pin direction control sit outside the block; the block only reports, through an enable output, when it wants to drive the pin.

Top module: `mm_timer`

## Requirements
- R1: After reset, the count and reload register are all ones, the stop bit is 1, the mode is 00 (plain timer), the polarity bit is 0, the slow source is selected, `irq_o` is 0, `cntr_oe_o` is 0 and `cntr_o` is 1; while stopped the count does not move.
- R2: In modes 00 and 01 with reload value n, consecutive underflows are exactly (n+1)*16 clocks apart when `cfg_fast` is 0, and (n+1)*2 clocks apart when it is 1.
- R3: A count pulse that finds the counter at zero loads the reload value into it and sets the interrupt flag; a count pulse that finds any other value lowers it by one.
- R4: The interrupt flag stays at 1 until an `irq_clr` strobe, which clears it one clock later; an underflow in the same cycle as the strobe leaves it at 1.
- R5: While the stop bit is 1, the count does not change in any mode, except through a reload write.
- R6: A reload write while the stop bit is 1 shows the written value on `count_o` one clock later.
- R7: `cntr_oe_o` is 1 only in mode 01. Any configuration write sets `cntr_o` to the inverse of the written polarity bit, so the pin starts high for polarity 0 and low for polarity 1. In mode 01 the pin then inverts at every underflow.
- R8: In mode 10, after a two-flop synchronizer, each rising edge on `cntr_i` (polarity 0) or each falling edge (polarity 1) is one count pulse; the opposite edge and the source ticks have no effect.
- R9: In mode 11 the selected source tick counts only while the synchronized `cntr_i` is high (polarity 0) or low (polarity 1); at the other level the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload_we | input | 1 | Write strobe for the reload register |
| reload_wd | input | 8 | Value written to the reload register |
| cfg_we | input | 1 | Write strobe for mode, polarity, source and stop |
| cfg_mode | input | 2 | 00 timer, 01 pulse output, 10 event count, 11 pulse width |
| cfg_pol | input | 1 | Polarity: edge, measured level, or first output level |
| cfg_fast | input | 1 | 0 selects clock/16, 1 selects clock/2 |
| cfg_stop | input | 1 | 1 freezes the counter |
| irq_clr | input | 1 | Strobe clearing the interrupt flag |
| count_o | output | 8 | Current counter value |
| irq_o | output | 1 | Sticky interrupt request |
| cntr_i | input | 1 | Timer pin, input direction |
| cntr_o | output | 1 | Timer pin, output value |
| cntr_oe_o | output | 1 | Pin output enable, high in pulse-output mode |

## Verification
A divider phase that is off, or a reload that misses the zero state, changes the distance between interrupts by at least one clock. That error shows on the second underflow after configuration, and the bench measures it in clocks against (n+1) times the source period. A wrong count-enable decode for a mode shows on `count_o` within a few clocks of a pin edge or level change: the value moves where it should hold, or holds where it should drop. A bad output-pin toggle state is visible as the pin level sampled at two consecutive interrupts.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
   typedef enum logic [1:0] {
      MMT_TIMER = 2'b00,
      MMT_PULSE = 2'b01,
      MMT_EVENT = 2'b10,
      MMT_WIDTH = 2'b11
   } mmt_mode_e;
endpackage

// File: rtl/mmt_prescale.sv
module mmt_prescale #(
   parameter int DIV_SLOW = 16,
   parameter int DIV_FAST = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_slow,
   output logic tick_fast
);
   localparam int PH_W   = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
   localparam int FAST_W = (DIV_FAST > 1) ? $clog2(DIV_FAST) : 1;

   generate
      if (DIV_SLOW < 2 || (DIV_SLOW & (DIV_SLOW - 1)) != 0)
         $error("DIV_SLOW must be a power of two of at least 2");
      if (DIV_FAST < 1 || DIV_FAST >= DIV_SLOW || (DIV_FAST & (DIV_FAST - 1)) != 0)
         $error("DIV_FAST must be a power of two below DIV_SLOW");
   endgenerate

   logic [PH_W-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= '0;
      else        ph_q <= ph_q + 1'b1;
   end

   assign tick_slow = &ph_q;

   generate
      if (DIV_FAST == 1) begin : g_fast_every
         assign tick_fast = 1'b1;
      end else begin : g_fast_div
         assign tick_fast = &ph_q[FAST_W-1:0];
      end
   endgenerate

   // slow tick lands on a fast tick, and never in two clocks running
   assert_slow_on_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_slow |-> tick_fast);
   assert_slow_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_slow |=> !tick_slow);
endmodule

// File: rtl/mmt_pin_sync.sv
module mmt_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   generate
      if (STAGES < 2) $error("STAGES must be at least 2");
   endgenerate

   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], pin_i};
         prev_q <= sh_q[STAGES-1];
      end
   end

   assign level_o = sh_q[STAGES-1];
   assign rise_o  = level_o & ~prev_q;
   assign fall_o  = ~level_o & prev_q;

   // one edge yields exactly one pulse
   assert_rise_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
   assert_fall_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
endmodule

// File: rtl/mmt_counter.sv
module mmt_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnt_en,
   input  logic         load_now,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] reload_val,
   output logic [W-1:0] count_o,
   output logic         underflow_o
);
   logic [W-1:0] cnt_q;

   assign underflow_o = cnt_en && !load_now && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '1;
      else if (load_now)    cnt_q <= load_val;
      else if (underflow_o) cnt_q <= reload_val;
      else if (cnt_en)      cnt_q <= cnt_q - 1'b1;
   end

   assign count_o = cnt_q;

   assert_reload_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !load_now && cnt_q == '0) |=> cnt_q == $past(reload_val));
   assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !load_now && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
   assert_direct_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_now |=> cnt_q == $past(load_val));
endmodule

// File: rtl/mm_timer.sv
module mm_timer
   import mmt_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int DIV_SLOW    = 16,
   parameter int DIV_FAST    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload_we,
   input  logic [CNT_W-1:0] reload_wd,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_mode,
   input  logic             cfg_pol,
   input  logic             cfg_fast,
   input  logic             cfg_stop,
   input  logic             irq_clr,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o,
   input  logic             cntr_i,
   output logic             cntr_o,
   output logic             cntr_oe_o
);
   generate
      if (CNT_W < 2) $error("CNT_W must be at least 2");
   endgenerate

   mmt_mode_e        mode_q;
   logic             pol_q, fast_q, stop_q, irq_q, out_q;
   logic [CNT_W-1:0] reload_q;
   logic             tick_slow, tick_fast, src_tick;
   logic             pin_lvl, pin_rise, pin_fall;
   logic             pulse_raw, cnt_en, uf;

   mmt_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast));

   mmt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(cntr_i),
      .level_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall));

   always_comb begin
      src_tick  = fast_q ? tick_fast : tick_slow;
      pulse_raw = 1'b0;
      case (mode_q)
         MMT_TIMER: pulse_raw = src_tick;
         MMT_PULSE: pulse_raw = src_tick;
         MMT_EVENT: pulse_raw = pol_q ? pin_fall : pin_rise;
         MMT_WIDTH: pulse_raw = src_tick && (pin_lvl != pol_q);
      endcase
      cnt_en = pulse_raw && !stop_q;
   end

   mmt_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
      .load_now(reload_we && stop_q), .load_val(reload_wd),
      .reload_val(reload_q), .count_o(count_o), .underflow_o(uf));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MMT_TIMER;
         pol_q    <= 1'b0;
         fast_q   <= 1'b0;
         stop_q   <= 1'b1;
         reload_q <= '1;
      end else begin
         if (cfg_we) begin
            mode_q <= mmt_mode_e'(cfg_mode);
            pol_q  <= cfg_pol;
            fast_q <= cfg_fast;
            stop_q <= cfg_stop;
         end
         if (reload_we) reload_q <= reload_wd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_q <= 1'b0;
      else if (uf)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         out_q <= 1'b1;
      else if (cfg_we)                    out_q <= ~cfg_pol;
      else if (uf && mode_q == MMT_PULSE) out_q <= ~out_q;
   end

   assign irq_o     = irq_q;
   assign cntr_o    = out_q;
   assign cntr_oe_o = (mode_q == MMT_PULSE);

   assert_irq_on_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      uf |=> irq_q);
   assert_irq_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !irq_clr) |=> irq_q);
   assert_frozen_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !reload_we) |=> $stable(count_o));
   assert_pin_moves_on_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we && !uf) |=> $stable(cntr_o));
endmodule

// File: tb/mm_timer_test.sv
module mm_timer_test;
   localparam int CLK_P = 10;
   localparam int NV    = 7;
   // {mode[27:26], pol[25], fast[24], reload[23:16], period[15:0]}
   localparam logic [27:0] VEC [NV] = '{
      {2'b00, 1'b0, 1'b0, 8'd3,   16'd64},
      {2'b00, 1'b0, 1'b1, 8'd0,   16'd2},
      {2'b00, 1'b0, 1'b1, 8'd5,   16'd12},
      {2'b00, 1'b0, 1'b0, 8'd0,   16'd16},
      {2'b01, 1'b0, 1'b1, 8'd7,   16'd16},
      {2'b01, 1'b1, 1'b0, 8'd1,   16'd32},
      {2'b00, 1'b0, 1'b1, 8'd255, 16'd512}
   };

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       reload_we = 1'b0, cfg_we = 1'b0, irq_clr = 1'b0, cntr_i = 1'b0;
   logic [7:0] reload_wd = '0;
   logic [1:0] cfg_mode = '0;
   logic       cfg_pol = 1'b0, cfg_fast = 1'b0, cfg_stop = 1'b1;
   logic [7:0] count_o;
   logic       irq_o, cntr_o, cntr_oe_o;
   int checks = 0, failures = 0, cyc = 0;

   mm_timer uut (
      .clk(clk), .rst_n(rst_n), .reload_we(reload_we), .reload_wd(reload_wd),
      .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_pol(cfg_pol), .cfg_fast(cfg_fast),
      .cfg_stop(cfg_stop), .irq_clr(irq_clr), .count_o(count_o), .irq_o(irq_o),
      .cntr_i(cntr_i), .cntr_o(cntr_o), .cntr_oe_o(cntr_oe_o));

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   initial begin
      #(CLK_P * 150000);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] m, input logic p, input logic f, input logic s);
      cfg_mode = m; cfg_pol = p; cfg_fast = f; cfg_stop = s; cfg_we = 1'b1;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic load(input logic [7:0] v);
      reload_wd = v; reload_we = 1'b1;
      @(negedge clk); reload_we = 1'b0;
   endtask

   task automatic clr;
      irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wait_irq(input int lim, output int t);
      int g = 0;
      while (!irq_o && g < lim) begin @(negedge clk); g++; end
      t = cyc;
   endtask

   task automatic pin(input logic v);
      cntr_i = v; idle(6);
   endtask

   initial begin
      int t1, t2;
      logic o1;
      logic [7:0] snap;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(count_o == 8'hFF, "R1 count", count_o, 255);
      chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
      chk(cntr_oe_o == 1'b0, "R1 oe", cntr_oe_o, 0);
      chk(cntr_o == 1'b1, "R1 pin level", cntr_o, 1);
      idle(50);
      chk(count_o == 8'hFF, "R1 stopped after reset", count_o, 255);

      // R6 direct preset while stopped
      load(8'h5A);
      chk(count_o == 8'h5A, "R6 preset", count_o, 90);

      // table walk: R2 period, R3 reload value, R7 pin behaviour
      for (int i = 0; i < NV; i++) begin
         logic [1:0] m; logic p, f; logic [7:0] n; int per;
         m = VEC[i][27:26]; p = VEC[i][25]; f = VEC[i][24];
         n = VEC[i][23:16]; per = int'(VEC[i][15:0]);
         cfg(m, p, f, 1'b1);
         load(n);
         clr();
         cfg(m, p, f, 1'b0);
         chk(cntr_oe_o == (m == 2'b01), "R7 oe", cntr_oe_o, int'(m == 2'b01));
         if (m == 2'b01) chk(cntr_o == ~p, "R7 start level", cntr_o, int'(~p));
         wait_irq(10000, t1);
         chk(count_o == n, "R3 reloaded at underflow", count_o, n);
         o1 = cntr_o;
         clr();
         wait_irq(10000, t2);
         chk(t2 - t1 == per, "R2 underflow interval", t2 - t1, per);
         if (m == 2'b01) chk(cntr_o == ~o1, "R7 toggle", cntr_o, int'(~o1));
         clr();
      end

      // R4 sticky flag and clear
      cfg(2'b00, 1'b0, 1'b1, 1'b1);
      load(8'd3);
      clr();
      cfg(2'b00, 1'b0, 1'b1, 1'b0);
      wait_irq(1000, t1);
      cfg(2'b00, 1'b0, 1'b1, 1'b1);
      idle(20);
      chk(irq_o == 1'b1, "R4 sticky", irq_o, 1);
      clr();
      chk(irq_o == 1'b0, "R4 cleared", irq_o, 0);

      // R5 stop while running
      load(8'd200);
      cfg(2'b00, 1'b0, 1'b1, 1'b0);
      idle(30);
      cfg(2'b00, 1'b0, 1'b1, 1'b1);
      snap = count_o;
      chk(snap < 8'd200, "R5 was running", snap, 199);
      idle(100);
      chk(count_o == snap, "R5 frozen timer", count_o, snap);

      // R8 event mode, rising edges
      cfg(2'b10, 1'b0, 1'b0, 1'b1);
      load(8'd3);
      clr();
      cfg(2'b10, 1'b0, 1'b0, 1'b0);
      idle(40);
      chk(count_o == 8'd3, "R8 no tick counting", count_o, 3);
      pin(1'b1);
      chk(count_o == 8'd2, "R8 rise counted", count_o, 2);
      pin(1'b0);
      chk(count_o == 8'd2, "R8 fall ignored", count_o, 2);
      pin(1'b1); pin(1'b0); pin(1'b1); pin(1'b0);
      chk(count_o == 8'd0, "R8 down to zero", count_o, 0);
      pin(1'b1);
      chk(count_o == 8'd3 && irq_o, "R8 underflow reload", count_o, 3);
      pin(1'b0);
      clr();

      // R8 event mode, falling edges
      cfg(2'b10, 1'b1, 1'b0, 1'b1);
      load(8'd3);
      cfg(2'b10, 1'b1, 1'b0, 1'b0);
      pin(1'b1);
      chk(count_o == 8'd3, "R8 rise ignored pol1", count_o, 3);
      pin(1'b0);
      chk(count_o == 8'd2, "R8 fall counted pol1", count_o, 2);

      // R5 stop in event mode
      cfg(2'b10, 1'b1, 1'b0, 1'b1);
      pin(1'b1); pin(1'b0);
      chk(count_o == 8'd2, "R5 frozen event", count_o, 2);

      // R9 pulse width, high level
      cfg(2'b11, 1'b0, 1'b1, 1'b1);
      load(8'd200);
      cfg(2'b11, 1'b0, 1'b1, 1'b0);
      idle(40);
      chk(count_o == 8'd200, "R9 holds while low", count_o, 200);
      cntr_i = 1'b1; idle(40); cntr_i = 1'b0; idle(10);
      chk(count_o == 8'd180, "R9 counts while high", count_o, 180);

      // R9 pulse width, low level
      pin(1'b1);
      cfg(2'b11, 1'b1, 1'b1, 1'b1);
      load(8'd200);
      cfg(2'b11, 1'b1, 1'b1, 1'b0);
      idle(40);
      chk(count_o == 8'd200, "R9 holds while high pol1", count_o, 200);
      cntr_i = 1'b0; idle(40); cntr_i = 1'b1; idle(10);
      chk(count_o == 8'd180, "R9 counts while low pol1", count_o, 180);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule